// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital front end of a single-channel voltage DAC. A host drives a three-wire serial stream into it: a serial clock, a data line and an active-low select/load strobe. When the strobe rises, the block decodes a 4-bit command from the frame. A command can load a 16-bit code into a staging register, copy the staging register into the output code register, do both at once, or put the converter to sleep. The output code register and a sleep flag go to the analog side.

A separate active-low update pin transfers the staging register to the output register without a serial command. How it acts depends on the select strobe: it can defer an update until the end of a transfer, and it can block a sleep request. An active-low clear pin forces both code registers to a reset code at once. A build parameter sets that reset code to zero or to midscale.

A serial output presents the last stage of a 32-bit shift register, so several devices can be chained. All pins are sampled by a fast system clock. That clock must run at least four times faster than the serial clock.

Top module: `sdac_cmd_if`

## Requirements
- R1: After power-on reset, and asynchronously while `clrN` is low, the staging and output code registers hold the reset code: 0x0000, or 0x8000 when `CLEAR_MID`=1. The sleep flag is 0 after power-on reset.
- R2: Command 0000, taken from frame bits [23:20], loads frame bits [15:0] into the staging register. It leaves `dacCode` and `pwrDown` unchanged.
- R3: Command 0001 copies the staging register into `dacCode` and clears `pwrDown`.
- R4: Command 0011 loads the frame data and sets `dacCode` to that data in the same step. It clears `pwrDown`.
- R5: Command 0100 sets `pwrDown`. It ignores the frame data and does not alter either code register.
- R6: Command 1111 and every reserved code (0010, 0101 to 1110) change nothing.
- R7: A 32-bit frame is decoded from its last 24 bits. The 8 leading bits have no effect.
- R8: If fewer than 24 serial clock rising edges occur while `csLdN` is low, the transfer is discarded when `csLdN` rises.
- R9: Serial clock edges while `csLdN` is high do not shift the register.
- R10: `sdoOut` presents a bit 32 serial rising edges after it entered. The output changes on the serial clock falling edge and stays driven while `csLdN` is high.
- R11: A falling edge on `ldacN` while `csLdN` is high copies the staging register into `dacCode` and clears `pwrDown`.
- R12: An `ldacN` low pulse that ends while `csLdN` is low clears `pwrDown` but does not update `dacCode`. If `ldacN` is still low when `csLdN` rises, the frame's command executes first and `dacCode` is then loaded from the staging register.
- R13: While `ldacN` is low, `pwrDown` is held at 0. A sleep command that executes while `ldacN` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rstN | input | 1 | Active-low power-on reset |
| sclkIn | input | 1 | Serial clock |
| sdiIn | input | 1 | Serial data in, shifted on the serial clock rising edge |
| csLdN | input | 1 | Active-low select; its rising edge executes the frame |
| clrN | input | 1 | Active-low asynchronous clear of both code registers |
| ldacN | input | 1 | Active-low asynchronous update request |
| sdoOut | output | 1 | Daisy-chain serial data out |
| dacCode | output | CODE_W | Output code register driven to the converter |
| pwrDown | output | 1 | Sleep indication to the analog side |

## Verification
The bench sweeps all sixteen command codes from a state where the staging register, the output register and the sleep flag all differ. It also probes the staging register afterwards with an update command. This exposes a reserved code decoded as a write, a sleep command that corrupts a register, and a combined command that copies stale staging data. Misaligned frames are covered by a 32-bit frame whose leading byte looks like a write-and-update, and by a 20-edge transfer. A decoder that used the first bits, or that did not count edges, would change the output. The update-pin cases cover a pulse during a transfer, a level held through the strobe rise, and a sleep request under a held level. A design that updated too early, updated too late or let the sleep through would show a wrong code or a raised sleep flag. The daisy-chain test clocks the serial line while deselected and then reads a whole earlier word back from the serial output. This catches stray shifting and an off-by-one in the output stage.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [3:0] {
    CMD_WRITE  = 4'b0000,
    CMD_UPDATE = 4'b0001,
    CMD_WRUPD  = 4'b0011,
    CMD_SLEEP  = 4'b0100,
    CMD_NOP    = 4'b1111
  } cmd_e;

  // strobes from control to datapath, one system cycle each (powerUp is a level)
  typedef struct packed {
    logic shift;
    logic sdoStep;
    logic loadIn;
    logic update;
    logic powerDown;
    logic powerUp;
  } strobe_t;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int MIN_BITS = 24,
  parameter int CMD_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkS,
  input  logic             csS,
  input  logic             ldacS,
  input  logic [CMD_W-1:0] frameCmd,
  output strobe_t          strb
);

  localparam int CNT_W = $clog2(MIN_BITS + 1);

  logic sclkPrev, csPrev, ldacPrev;
  logic sclkRise, sclkFall, csRise, ldacFall, ldacLow;
  logic [CNT_W-1:0] bitCnt;
  logic execNow, frameFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      csPrev   <= 1'b1;
      ldacPrev <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
      ldacPrev <= ldacS;
    end
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign csRise   = csS & ~csPrev;
  assign ldacFall = ~ldacS & ldacPrev;
  assign ldacLow  = ~ldacS;

  // saturating count of rising edges seen while selected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csS) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != CNT_W'(MIN_BITS)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign frameFull = (bitCnt == CNT_W'(MIN_BITS));
  assign execNow   = csRise & frameFull;

  always_comb begin
    strb = '0;
    strb.shift   = sclkRise & ~csS;
    strb.sdoStep = sclkFall;
    if (execNow) begin
      case (frameCmd)
        CMD_WRITE:  strb.loadIn = 1'b1;
        CMD_UPDATE: strb.update = 1'b1;
        CMD_WRUPD: begin
          strb.loadIn = 1'b1;
          strb.update = 1'b1;
        end
        CMD_SLEEP:  strb.powerDown = ~ldacLow;
        default:    ;
      endcase
      // update level held through the strobe rise: apply after the command
      if (ldacLow) strb.update = 1'b1;
    end
    // update-pin edge while deselected acts at once
    if (ldacFall && csS && !csRise) strb.update = 1'b1;
    strb.powerUp = ldacLow | strb.update;
  end

  // R8
  short_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && !frameFull) |-> !(strb.loadIn || strb.powerDown));

  // R12
  ldac_deferred_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldacFall && !csS) |-> !strb.update);

endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SR_W = 32,
  parameter int MIN_BITS = 24,
  parameter int CMD_W = 4,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              sdiS,
  input  strobe_t           strb,
  output logic [CMD_W-1:0]  frameCmd,
  output logic [CODE_W-1:0] dacCode,
  output logic              pwrDown,
  output logic              sdoOut
);

  logic [SR_W-1:0]   shiftReg;
  logic [CODE_W-1:0] inputReg, dacReg, frameData;
  logic              pdReg, sdoReg, regRstN;

  assign regRstN   = rstN & clrN;
  assign frameCmd  = shiftReg[MIN_BITS-1 -: CMD_W];
  assign frameData = shiftReg[CODE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= 1'b0;
    end else begin
      if (strb.shift)   shiftReg <= {shiftReg[SR_W-2:0], sdiS};
      if (strb.sdoStep) sdoReg   <= shiftReg[SR_W-1];
    end
  end

  always_ff @(posedge clk or negedge regRstN) begin
    if (!regRstN) begin
      inputReg <= RESET_CODE;
      dacReg   <= RESET_CODE;
    end else begin
      if (strb.loadIn) inputReg <= frameData;
      if (strb.update) dacReg   <= strb.loadIn ? frameData : inputReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pdReg <= 1'b0;
    else if (strb.powerUp)    pdReg <= 1'b0;
    else if (strb.powerDown)  pdReg <= 1'b1;
  end

  assign dacCode = dacReg;
  assign pwrDown = pdReg;
  assign sdoOut  = sdoReg;

  // R5
  sleep_keeps_code_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    $rose(pdReg) |-> $stable(dacReg));

  // R6
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !strb.update |=> $stable(dacReg));

  // R10
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdoReg) |-> $past(strb.sdoStep));

endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
  import sdac_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SR_W = 32,
  parameter int MIN_BITS = 24,
  parameter bit CLEAR_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic              csLdN,
  input  logic              clrN,
  input  logic              ldacN,
  output logic              sdoOut,
  output logic [CODE_W-1:0] dacCode,
  output logic              pwrDown
);

  localparam int CMD_W = 4;
  localparam logic [CODE_W-1:0] RESET_CODE =
    CLEAR_MID ? (CODE_W'(1) << (CODE_W - 1)) : '0;

  logic [3:0]       rawPins, syncPins;
  logic             sclkS, sdiS, csS, ldacS;
  logic [CMD_W-1:0] frameCmd;
  strobe_t          strb;

  assign rawPins = {sclkIn, sdiIn, csLdN, ldacN};

  sdac_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1011)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawPins),
    .syncOut (syncPins)
  );

  assign {sclkS, sdiS, csS, ldacS} = syncPins;

  sdac_ctrl #(.MIN_BITS(MIN_BITS), .CMD_W(CMD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkS    (sclkS),
    .csS      (csS),
    .ldacS    (ldacS),
    .frameCmd (frameCmd),
    .strb     (strb)
  );

  sdac_datapath #(
    .CODE_W(CODE_W), .SR_W(SR_W), .MIN_BITS(MIN_BITS),
    .CMD_W(CMD_W), .RESET_CODE(RESET_CODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .clrN     (clrN),
    .sdiS     (sdiS),
    .strb     (strb),
    .frameCmd (frameCmd),
    .dacCode  (dacCode),
    .pwrDown  (pwrDown),
    .sdoOut   (sdoOut)
  );

  // R1
  clear_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> dacCode == RESET_CODE);

  // R13
  ldac_wakes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldacS |=> !pwrDown);

  // R9
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> $stable(frameCmd));

endmodule

// File: tb/sim_sdac_cmd_if.sv
module sim_sdac_cmd_if;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1, sdi = 1'b0, csLdN = 1'b1, clrN = 1'b1, ldacN = 1'b1;
  logic sdo, sdo1, pd, pd1;
  logic [15:0] dac, dac1;
  logic [31:0] sdoSeen;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdac_cmd_if u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .sdiIn(sdi), .csLdN(csLdN),
    .clrN(clrN), .ldacN(ldacN), .sdoOut(sdo), .dacCode(dac), .pwrDown(pd)
  );

  sdac_cmd_if #(.CLEAR_MID(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .sdiIn(sdi), .csLdN(csLdN),
    .clrN(clrN), .ldacN(ldacN), .sdoOut(sdo1), .dacCode(dac1), .pwrDown(pd1)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w, input int n, input int ldacMode);
    csLdN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (ldacMode != 0 && i == 4) ldacN = 1'b0;
      if (ldacMode == 1 && i == 8) ldacN = 1'b1;
      sdi = w[n-1-i];
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sdoSeen[31-i] = sdo;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    csLdN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input logic [3:0] cmd, input logic [15:0] data);
    sendWord({8'h00, cmd, 4'h0, data}, 24, 0);
  endtask

  task automatic ldacPulse();
    ldacN = 1'b0;
    repeat (8) @(negedge clk);
    ldacN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    checkEq("R1 reset code", dac, 16'h0000);
    checkEq("R1 reset midscale variant", dac1, 16'h8000);
    checkEq("R1 reset sleep flag", pd, 0);
    checkEq("R10 reset serial out", sdo, 0);

    // R2..R6: sweep every command code
    for (int c = 0; c < 16; c++) begin
      logic [15:0] a, b, d, inExp, dacExp;
      logic pdExp;
      a = 16'h0100 + 16'(c);
      b = 16'hA000 + 16'(c);
      d = 16'h5A00 + 16'(c * 17);
      frame(4'b0011, b);
      frame(4'b0000, a);
      frame(4'b0100, 16'hFFFF);
      frame(4'(c), d);
      inExp  = (c == 0 || c == 3) ? d : a;
      dacExp = (c == 1) ? a : ((c == 3) ? d : b);
      pdExp  = (c == 1 || c == 3) ? 1'b0 : 1'b1;
      checkEq($sformatf("R2 R3 R4 R6 code %0d output", c), dac, dacExp);
      checkEq($sformatf("R3 R4 R5 code %0d sleep", c), pd, pdExp);
      frame(4'b0001, 16'h0000);
      checkEq($sformatf("R2 R5 R6 code %0d staging", c), dac, inExp);
      checkEq($sformatf("R3 code %0d wake", c), pd, 0);
    end

    // R7 32-bit frame, misleading leading byte
    frame(4'b0011, 16'h1111);
    sendWord({8'h3F, 4'b0000, 4'hF, 16'h7E57}, 32, 0);
    checkEq("R7 leading byte ignored", dac, 16'h1111);
    frame(4'b0001, 16'h0000);
    checkEq("R7 data from last 24 bits", dac, 16'h7E57);

    // R8 short transfer
    sendWord({12'h000, 4'b0011, 16'hBEEF}, 20, 0);
    checkEq("R8 short transfer discarded", dac, 16'h7E57);
    frame(4'b0001, 16'h0000);
    checkEq("R8 staging untouched", dac, 16'h7E57);

    // R9 / R10 daisy chain with deselected clocking
    sendWord(32'hA5FF1234, 32, 0);
    sdi = 1'b1;
    for (int k = 0; k < 6; k++) begin
      sclk = 1'b0; repeat (4) @(negedge clk);
      sclk = 1'b1; repeat (4) @(negedge clk);
    end
    sendWord(32'h00F00000, 32, 0);
    checkEq("R9 R10 word returned on serial out", sdoSeen, 32'hA5FF1234);

    // R11 update pin while deselected
    frame(4'b0100, 16'h0000);
    frame(4'b0000, 16'h2468);
    checkEq("R11 before pulse", dac, 16'h7E57);
    ldacPulse();
    checkEq("R11 pulse updates output", dac, 16'h2468);
    checkEq("R11 pulse wakes", pd, 0);

    // R12 pulse inside a transfer
    frame(4'b0100, 16'h0000);
    sendWord({8'h00, 4'b0000, 4'h0, 16'h1357}, 24, 1);
    checkEq("R12 pulse in transfer no update", dac, 16'h2468);
    checkEq("R12 pulse in transfer wakes", pd, 0);
    // level held through strobe rise
    sendWord({8'h00, 4'b0000, 4'h0, 16'h9ABC}, 24, 2);
    checkEq("R12 held level deferred update", dac, 16'h9ABC);

    // R13 sleep blocked by held level, then honoured once released
    sendWord({8'h00, 4'b0100, 4'h0, 16'h0000}, 24, 0);
    checkEq("R13 sleep ignored while low", pd, 0);
    ldacN = 1'b1;
    repeat (8) @(negedge clk);
    checkEq("R13 still awake after release", pd, 0);
    frame(4'b0100, 16'h0000);
    checkEq("R5 sleep after release", pd, 1);
    ldacN = 1'b0;
    repeat (8) @(negedge clk);
    checkEq("R13 low level wakes", pd, 0);
    ldacN = 1'b1;
    repeat (8) @(negedge clk);

    // R1 asynchronous clear
    frame(4'b0011, 16'h4321);
    #3 clrN = 1'b0;
    #2;
    checkEq("R1 clear immediate", dac, 16'h0000);
    checkEq("R1 clear midscale variant", dac1, 16'h8000);
    repeat (3) @(negedge clk);
    clrN = 1'b1;
    repeat (3) @(negedge clk);
    frame(4'b0001, 16'h0000);
    checkEq("R1 staging cleared", dac, 16'h0000);
    checkEq("R1 staging cleared midscale", dac1, 16'h8000);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule